// File: doc/BRIEF.md
# CPU Reset Entry Sequencer

This block sits between the raw active-low reset request of an 8-bit controller and its execution core. It synchronizes the request, accepts it only once it has stayed low for a minimum number of clock cycles, and keeps the core's memory strobes blocked for as long as the core is not running. When the accepted request goes away, the block runs the start-up sequence. It first waits a fixed number of cycles. It then raises a one-cycle pulse that sets the interrupt-mask flag and reads the two start-address bytes over a synchronous read port. Last, it hands the 16-bit start address to the program counter and lets the core run.

A new accepted request at any point in the sequence, or while the core runs, stops the core and starts the hold again. The block-level reset `rst_n` puts the block in the held state. Its release therefore behaves like the end of a request, and the core boots through the same sequence.

Top module: `cpu_start_seq`

## Requirements
- R1: `rst_req_n_i` passes through a two-flop synchronizer. A request counts only after MIN_LOW (default 2) consecutive low synchronized samples. A shorter low pulse leaves `run_o` at 1 and produces no `pc_load_o`. The low-sample count restarts whenever the line is high.
- R2: `mem_rd_o` and `mem_wr_o` follow `core_rd_i` and `core_wr_i` only while `run_o` is 1 and the synchronized request line is high. Otherwise both are 0.
- R3: The sequence starts when the line returns high after an accepted request. Let k count the falling clock edges after the raw line is raised, starting at 1. Then `pc_load_o` is seen high at k = INIT_CYCLES+5 (11 by default).
- R4: The block waits INIT_CYCLES (default 6) cycles after the release before any vector read. No `vec_re_o` and no `mask_set_o` occur during the wait.
- R5: `mask_set_o` pulses for exactly one cycle, at k = INIT_CYCLES+3. It coincides with the low-byte read, where `vec_re_o` is 1 and `vec_addr_o` is 0xFFFC.
- R6: The block reads address 0xFFFC and then 0xFFFD in consecutive cycles. Read data returns one cycle after `vec_re_o`. `pc_load_o` is high for one cycle, with `pc_value_o` = {byte at 0xFFFD, byte at 0xFFFC}. `pc_value_o` is 0 whenever `pc_load_o` is 0.
- R7: `run_o` rises in the cycle after `pc_load_o` (k = INIT_CYCLES+6) and stays high until the next accepted request.
- R8: An accepted request during the sequence aborts it. `run_o` stays 0, and no `mask_set_o` or `pc_load_o` occurs until the line rises again. After that rise, the full sequence runs with the R3 timing.
- R9: While `rst_n` is low, `run_o`, `vec_re_o`, `mask_set_o` and `pc_load_o` are 0 and the block is in the held state. After `rst_n` rises with the request line high, the sequence runs with the R3 timing, counted from the release of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Block reset, asynchronous assert, synchronous release |
| rst_req_n_i | input | 1 | Asynchronous active-low reset request |
| core_rd_i | input | 1 | Core read strobe |
| core_wr_i | input | 1 | Core write strobe |
| mem_rd_o | output | 1 | Gated read strobe to memory |
| mem_wr_o | output | 1 | Gated write strobe to memory |
| vec_re_o | output | 1 | Vector read enable |
| vec_addr_o | output | 16 | Vector read address |
| vec_data_i | input | 8 | Vector read data, one cycle after enable |
| mask_set_o | output | 1 | One-cycle pulse that sets the interrupt mask |
| pc_load_o | output | 1 | One-cycle program-counter load pulse |
| pc_value_o | output | 16 | Start address, valid with `pc_load_o` |
| run_o | output | 1 | Core released |

## Verification
The bench builds the block with its defaults: a minimum low width of 2, a wait of 6 cycles and vector base 0xFFFC. Pulse widths of 1 and 2 cycles therefore sit on either side of the acceptance threshold. The whole wait, the fetch and the hand-off fit in a window of a dozen cycles, so each pulse can be checked to the exact cycle. The short wait also lets an abort land in the middle of the wait, before the first vector read.

// File: rtl/cse_pkg.sv
package cse_pkg;
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RD_LO = 3'd2,
    ST_RD_HI = 3'd3,
    ST_LOAD  = 3'd4,
    ST_RUN   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/cse_sync.sv
module cse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  // Reset value 0 reads as "request active"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cse_qual.sv
module cse_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s_i,
  output logic held_o,
  output logic rel_o
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          held_q, held_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    cnt_en = 1'b0;
    if (line_s_i) begin
      cnt_d  = '0;
      held_d = 1'b0;
      cnt_en = 1'b1;
    end else begin
      if (32'(cnt_q) < 32'(MIN_LOW)) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
      if (32'(cnt_q) + 32'd1 >= 32'(MIN_LOW)) held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(MIN_LOW);
      held_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      held_q <= held_d;
    end
  end

  assign held_o = held_q;
  assign rel_o  = held_q & line_s_i;
endmodule

// File: rtl/cse_seq.sv
module cse_seq
  import cse_pkg::*;
#(
  parameter int          INIT_CYCLES = 6,
  parameter int          AW          = 16,
  parameter int          DW          = 8,
  parameter logic [15:0] VEC_LO      = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            held_i,
  input  logic            rel_i,
  input  logic [DW-1:0]   vec_data_i,
  output logic            vec_re_o,
  output logic [AW-1:0]   vec_addr_o,
  output logic            mask_set_o,
  output logic            pc_load_o,
  output logic [2*DW-1:0] pc_value_o,
  output logic            run_o
);
  localparam int ICW = $clog2(INIT_CYCLES + 1);
  localparam logic [ICW-1:0] WAIT_LAST = ICW'(INIT_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic [ICW-1:0] cnt_q, cnt_d;
  logic [DW-1:0]  lo_q, lo_d;
  logic           cnt_en, lo_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lo_d    = lo_q;
    cnt_en  = 1'b0;
    lo_en   = 1'b0;
    if (rel_i) begin
      state_d = ST_WAIT;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (held_i) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: state_d = ST_HOLD;
        ST_WAIT: begin
          if (cnt_q == WAIT_LAST) begin
            state_d = ST_RD_LO;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        ST_RD_LO: state_d = ST_RD_HI;
        ST_RD_HI: begin
          lo_d    = vec_data_i;
          lo_en   = 1'b1;
          state_d = ST_LOAD;
        end
        ST_LOAD: state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (lo_en)  lo_q  <= lo_d;
    end
  end

  always_comb begin
    vec_re_o   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    vec_addr_o = '0;
    if (state_q == ST_RD_LO) vec_addr_o = AW'(VEC_LO);
    if (state_q == ST_RD_HI) vec_addr_o = AW'(VEC_LO) + 1'b1;
    mask_set_o = (state_q == ST_RD_LO);
    pc_load_o  = (state_q == ST_LOAD);
    pc_value_o = pc_load_o ? {vec_data_i, lo_q} : '0;
    run_o      = (state_q == ST_RUN);
  end
endmodule

// File: rtl/cpu_start_seq.sv
module cpu_start_seq #(
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_LOW     = 2,
  parameter int          INIT_CYCLES = 6,
  parameter int          AW          = 16,
  parameter int          DW          = 8,
  parameter logic [15:0] VEC_LO      = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req_n_i,
  input  logic            core_rd_i,
  input  logic            core_wr_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            vec_re_o,
  output logic [AW-1:0]   vec_addr_o,
  input  logic [DW-1:0]   vec_data_i,
  output logic            mask_set_o,
  output logic            pc_load_o,
  output logic [2*DW-1:0] pc_value_o,
  output logic            run_o
);
  logic line_s_w;
  logic held_w;
  logic rel_w;
  logic strobe_en_w;

  cse_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rst_req_n_i),
    .q_o   (line_s_w)
  );

  cse_qual #(.MIN_LOW(MIN_LOW)) qual_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s_i (line_s_w),
    .held_o   (held_w),
    .rel_o    (rel_w)
  );

  cse_seq #(
    .INIT_CYCLES (INIT_CYCLES),
    .AW          (AW),
    .DW          (DW),
    .VEC_LO      (VEC_LO)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .held_i     (held_w),
    .rel_i      (rel_w),
    .vec_data_i (vec_data_i),
    .vec_re_o   (vec_re_o),
    .vec_addr_o (vec_addr_o),
    .mask_set_o (mask_set_o),
    .pc_load_o  (pc_load_o),
    .pc_value_o (pc_value_o),
    .run_o      (run_o)
  );

  assign strobe_en_w = run_o & line_s_w;
  assign mem_rd_o    = core_rd_i & strobe_en_w;
  assign mem_wr_o    = core_wr_i & strobe_en_w;
endmodule

// File: rtl/cpu_start_seq_chk.sv
module cpu_start_seq_chk #(
  parameter int          AW     = 16,
  parameter int          DW     = 8,
  parameter logic [15:0] VEC_LO = 16'hFFFC
) (
  input logic            clk,
  input logic            rst_n,
  input logic            held_w,
  input logic            rel_w,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            vec_re_o,
  input logic [AW-1:0]   vec_addr_o,
  input logic            mask_set_o,
  input logic            pc_load_o,
  input logic [2*DW-1:0] pc_value_o,
  input logic            run_o
);
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (!mem_rd_o && !mem_wr_o)); // R2
  AST_MASK_WITH_LO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_o |-> (vec_re_o && vec_addr_o == AW'(VEC_LO))); // R5
  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_re_o && vec_addr_o == AW'(VEC_LO) && !held_w) |=> (vec_re_o && vec_addr_o == AW'(VEC_LO) + 1'b1)); // R6
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !pc_load_o); // R6
  AST_LOAD_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !held_w) |=> run_o); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_w && !rel_w) |=> !run_o); // R8
endmodule

bind cpu_start_seq cpu_start_seq_chk #(.AW(AW), .DW(DW), .VEC_LO(VEC_LO)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .held_w     (held_w),
  .rel_w      (rel_w),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .vec_re_o   (vec_re_o),
  .vec_addr_o (vec_addr_o),
  .mask_set_o (mask_set_o),
  .pc_load_o  (pc_load_o),
  .pc_value_o (pc_value_o),
  .run_o      (run_o)
);

// File: tb/cpu_start_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_start_seq_tb_top;
  localparam int INIT = 6;
  localparam int K_MASK = INIT + 3;
  localparam int K_LOAD = INIT + 5;
  localparam int K_RUN  = INIT + 6;

  // {low width in cycles, restart expected}
  localparam logic [8:0] PULSES [5] = '{
    {8'd1, 1'b0}, {8'd2, 1'b1}, {8'd3, 1'b1}, {8'd1, 1'b0}, {8'd6, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n, req_n, core_rd, core_wr;
  logic        mem_rd, mem_wr, vec_re, mask_set, pc_load, run;
  logic [15:0] vec_addr, pc_value;
  logic [7:0]  vec_data, lo_b, hi_b;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cpu_start_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_n_i(req_n),
    .core_rd_i(core_rd), .core_wr_i(core_wr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .vec_re_o(vec_re), .vec_addr_o(vec_addr), .vec_data_i(vec_data),
    .mask_set_o(mask_set), .pc_load_o(pc_load), .pc_value_o(pc_value),
    .run_o(run)
  );

  always_ff @(posedge clk) begin
    if (vec_re)
      vec_data <= (vec_addr == 16'hFFFC) ? lo_b : (vec_addr == 16'hFFFD) ? hi_b : 8'h00;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic watch_seq(input bit expect_run, input string req);
    int k_mask = 0, k_load = 0, k_run = 0, pcv = 0;
    bit saw_low = 1'b0;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (mask_set && k_mask == 0) k_mask = k;
      if (pc_load && k_load == 0) begin k_load = k; pcv = int'(pc_value); end
      if (!run) saw_low = 1'b1;
      if (run && saw_low && k_run == 0) k_run = k;
    end
    if (expect_run) begin
      check(k_mask == K_MASK, {req, "/R4/R5"}, "mask pulse cycle", k_mask, K_MASK);
      check(k_load == K_LOAD, {req, "/R3"}, "pc load cycle", k_load, K_LOAD);
      check(pcv == int'({hi_b, lo_b}), {req, "/R6"}, "start address", pcv, int'({hi_b, lo_b}));
      check(k_run == K_RUN, {req, "/R7"}, "run rise cycle", k_run, K_RUN);
    end else begin
      check(!saw_low, {req, "/R1"}, "run dropped on short pulse", int'(saw_low), 0);
      check(k_load == 0, {req, "/R1"}, "pc load on short pulse", k_load, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_n = 1'b1; core_rd = 1'b0; core_wr = 1'b0;
    lo_b = 8'h34; hi_b = 8'h12;
    repeat (3) @(negedge clk);
    core_rd = 1'b1;
    #1;
    check(run == 1'b0, "R9", "run in reset", int'(run), 0);
    check(mem_rd == 1'b0, "R2", "read strobe in reset", int'(mem_rd), 0);
    check(vec_re == 1'b0 && pc_load == 1'b0 && mask_set == 1'b0, "R9", "sequence outputs in reset",
          int'({vec_re, pc_load, mask_set}), 0);
    core_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    watch_seq(1'b1, "R9");

    core_wr = 1'b1;
    #1;
    check(mem_wr == 1'b1, "R2", "write strobe in run", int'(mem_wr), 1);
    check(pc_value == 16'h0, "R6", "pc value idle", int'(pc_value), 0);
    core_wr = 1'b0;
    @(negedge clk);

    foreach (PULSES[i]) begin
      lo_b = 8'h30 + 8'(i);
      hi_b = 8'hC0 + 8'(i);
      req_n = 1'b0;
      repeat (int'(PULSES[i][8:1])) @(negedge clk);
      req_n = 1'b1;
      watch_seq(PULSES[i][0], PULSES[i][0] ? "R3" : "R1");
    end

    // Abort inside the wait
    lo_b = 8'h5A; hi_b = 8'hE7;
    req_n = 1'b0;
    repeat (3) @(negedge clk);
    req_n = 1'b1;
    repeat (3) @(negedge clk);
    req_n = 1'b0;
    core_rd = 1'b1;
    begin
      int bad = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (mask_set || pc_load || vec_re) bad++;
      end
      check(bad == 0, "R8", "vector activity after abort", bad, 0);
      check(run == 1'b0, "R8", "run while aborted", int'(run), 0);
      check(mem_rd == 1'b0, "R2", "read strobe while held", int'(mem_rd), 0);
    end
    core_rd = 1'b0;
    req_n = 1'b1;
    watch_seq(1'b1, "R8");

    // Block reset while running
    rst_n = 1'b0;
    #1;
    check(run == 1'b0, "R9", "run after async reset", int'(run), 0);
    @(negedge clk);
    rst_n = 1'b1;
    watch_seq(1'b1, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule